// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit up-counters. Each has a mode word, a target value and a live count, all reached through a small register port: one write strobe, one read strobe, a channel number and a field selector. The mode word decides several things for its counter. It sets the wrap point, which is either the target or the full 16-bit range. It chooses which events raise an interrupt (reaching the target, overflowing at 0xFFFF, or both). It chooses whether that interrupt fires once or every time. Two sticky flags in the same word record target and overflow events, and both clear when software reads the mode word.

Each channel picks its own increment source. Channel 0 can follow a dot-rate pulse. Channel 1 can follow a horizontal-line pulse. Channel 2 can advance once every eight clocks, or it can be halted. When no source is selected, a channel counts every clock. All sources arrive as single-cycle enables, so the block runs in one clock domain. Each interrupt is a one-cycle pulse placed at a fixed bit of a 16-bit request word, and an outside interrupt controller latches it.

Top module: `pit_timer_bank`

## Requirements
- R1: After synchronous reset every count, target and mode word reads 0 and `irq_set` is all zero.
- R2: `reg_sel` encodes 0 = count, 1 = mode, 2 = target, 3 = nothing (reads 0, writes ignored). `reg_ch` values 0 to 2 pick a channel and 3 picks none. Count and target writes keep only `reg_wdata[15:0]`. A target write leaves the count unchanged.
- R3: Mode bit 3 clear: the count runs up to 0xFFFF and then wraps to 0. Each such wrap sets sticky flag bit 12 of the mode word.
- R4: Mode bit 3 set: on an increment whose result equals the target, the count becomes 0 instead. Every increment whose result equals the target sets sticky flag bit 11, in either wrap mode.
- R5: A mode read returns the word as it stands: bits 10..0 as written, flags in bits 11 and 12, and bits 15..13 always 0. The same clock edge then clears bits 11 and 12. An event on that same edge sets its flag again.
- R6: A mode write stores `reg_wdata[10:0]` and ignores `reg_wdata[15:11]`. It clears the count and both flags and re-arms the one-shot interrupt.
- R7: Mode bit 4 enables an interrupt on a target event, and bit 5 enables one on an overflow event. For channel n, an enabled event drives `irq_set[4+n]` high for exactly the one cycle after the edge on which it occurs. All other `irq_set` bits stay 0.
- R8: Mode bit 6 set: every enabled event pulses the interrupt. Bit 6 clear: only the first enabled event after a mode write pulses.
- R9: When mode bit 8 is set, channel 0 advances only on cycles with `dot_tick` high and channel 1 only on cycles with `line_tick` high. Otherwise these channels advance every clock.
- R10: For channel 2, mode bit 0 stops counting. With bit 0 clear and bit 9 set, it advances on the 8th, 16th, ... edge after its mode write. With both clear, it advances every clock.
- R11: On an edge where a channel's count, mode or target is written, that channel does not advance and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the selected field |
| reg_rd | input | 1 | Read strobe (applies read-clear on a mode read) |
| reg_ch | input | 2 | Channel number, 3 = none |
| reg_sel | input | 2 | Field: 0 count, 1 mode, 2 target |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 16 | Combinational read data of the selected field |
| dot_tick | input | 1 | Dot-rate increment enable for channel 0 |
| line_tick | input | 1 | Line-rate increment enable for channel 1 |
| irq_set | output | 16 | Interrupt request pulses, bits 4..6 for channels 0..2 |

## Verification
The bench goes after several corner cases, each of which a faulty design would show in a visible way. If a design compared the old count with the target instead of the incremented one, every target pulse would land one cycle late and the wrap period would grow by one. If a design cleared the flags with no regard to a same-edge event, it would lose a flag set on the very cycle software reads it. If a design failed to re-arm the one-shot state on a mode write, it would stay silent after reprogramming. If a design ignored the write-suppresses-increment rule, a freshly written count or target would be off by one. The bench also checks that the divide-by-eight phase restarts from the mode write, and it runs long random sequences of writes, reads and tick pulses against a model built from the requirements.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int REG_W       = 16;
    localparam int MODE_KEEP_W = 11;

    localparam int BIT_STOP     = 0;
    localparam int BIT_WRAP_TGT = 3;
    localparam int BIT_IRQ_TGT  = 4;
    localparam int BIT_IRQ_OVF  = 5;
    localparam int BIT_REPEAT   = 6;
    localparam int BIT_ALT_SRC  = 8;
    localparam int BIT_DIV      = 9;
    localparam int BIT_FLAG_TGT = 11;
    localparam int BIT_FLAG_OVF = 12;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_MODE   = 2'd1,
        SEL_TARGET = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] cnt;
        logic [REG_W-1:0] tgt;
        logic [REG_W-1:0] mode;
    } chan_view_t;

    typedef struct packed {
        logic hit;
        logic ovf;
    } chan_evt_t;

    function automatic logic [REG_W-1:0] pack_mode(
        input logic [MODE_KEEP_W-1:0] lo,
        input logic                   flag_tgt,
        input logic                   flag_ovf
    );
        logic [REG_W-1:0] r;
        r = '0;
        r[MODE_KEEP_W-1:0] = lo;
        r[BIT_FLAG_TGT]    = flag_tgt;
        r[BIT_FLAG_OVF]    = flag_ovf;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pick_field(
        input chan_view_t v,
        input reg_sel_e   s
    );
        case (s)
            SEL_COUNT:  return v.cnt;
            SEL_MODE:   return v.mode;
            SEL_TARGET: return v.tgt;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick_o = (pre_q == LAST);

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_cnt,
    input  logic             wr_mode,
    input  logic             wr_tgt,
    input  logic             rd_mode,
    input  logic [REG_W-1:0] wdata,
    output chan_view_t       view_o,
    output logic             irq_q
);
    localparam logic [REG_W-1:0] ALL_ONES = '1;

    logic [REG_W-1:0]       cnt_q;
    logic [REG_W-1:0]       tgt_q;
    logic [MODE_KEEP_W-1:0] mode_lo_q;
    logic                   flag_tgt_q;
    logic                   flag_ovf_q;
    logic                   fired_q;

    logic             any_wr;
    logic             step;
    logic [REG_W-1:0] cnt_inc;
    chan_evt_t        evt;
    logic             want_irq;
    logic             fire;

    always_comb begin
        any_wr   = wr_cnt | wr_mode | wr_tgt;
        step     = tick & ~any_wr;
        cnt_inc  = cnt_q + 1'b1;
        evt.hit  = step && (cnt_inc == tgt_q);
        evt.ovf  = step && (cnt_q == ALL_ONES);
        want_irq = (mode_lo_q[BIT_IRQ_TGT] & evt.hit) |
                   (mode_lo_q[BIT_IRQ_OVF] & evt.ovf);
        fire     = want_irq & (mode_lo_q[BIT_REPEAT] | ~fired_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            tgt_q      <= '0;
            mode_lo_q  <= '0;
            flag_tgt_q <= 1'b0;
            flag_ovf_q <= 1'b0;
            fired_q    <= 1'b0;
            irq_q      <= 1'b0;
        end else if (wr_mode) begin
            mode_lo_q  <= wdata[MODE_KEEP_W-1:0];
            cnt_q      <= '0;
            flag_tgt_q <= 1'b0;
            flag_ovf_q <= 1'b0;
            fired_q    <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            if (wr_cnt) begin
                cnt_q <= wdata;
            end else if (step) begin
                cnt_q <= (mode_lo_q[BIT_WRAP_TGT] && evt.hit) ? '0 : cnt_inc;
            end
            if (wr_tgt) begin
                tgt_q <= wdata;
            end
            flag_tgt_q <= (flag_tgt_q & ~rd_mode) | evt.hit;
            flag_ovf_q <= (flag_ovf_q & ~rd_mode) | evt.ovf;
            fired_q    <= fired_q | fire;
            irq_q      <= fire;
        end
    end

    always_comb begin
        view_o.cnt  = cnt_q;
        view_o.tgt  = tgt_q;
        view_o.mode = pack_mode(mode_lo_q, flag_tgt_q, flag_ovf_q);
    end

endmodule

// File: rtl/pit_read_mux.sv
module pit_read_mux
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CH_W   = 2
) (
    input  logic [CH_W-1:0]  reg_ch,
    input  reg_sel_e         sel,
    input  chan_view_t       view [NUM_CH],
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_ch == CH_W'(i)) begin
                rdata = pick_field(view[i], sel);
            end
        end
    end

endmodule

// File: rtl/pit_timer_bank.sv
module pit_timer_bank
    import pit_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int WDATA_W  = 32,
    parameter int PRE_DIV  = 8,
    parameter int IRQ_W    = 16,
    parameter int IRQ_BASE = 4,
    parameter int DIV_CH   = 2,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [CH_W-1:0]    reg_ch,
    input  logic [1:0]         reg_sel,
    input  logic [WDATA_W-1:0] reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               dot_tick,
    input  logic               line_tick,
    output logic [IRQ_W-1:0]   irq_set
);
    reg_sel_e            sel_e;
    chan_view_t          view [NUM_CH];
    logic [NUM_CH-1:0]   tick;
    logic [NUM_CH-1:0]   irq_q;
    logic [NUM_CH-1:0]   rep_vec;
    logic                div_stop;
    logic [NUM_CH*REG_W-1:0] cnt_flat;
    logic                wdata_unused;

    assign sel_e        = reg_sel_e'(reg_sel);
    assign wdata_unused = ^reg_wdata[WDATA_W-1:REG_W];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic ch_hit;
        logic wr_cnt;
        logic wr_mode;
        logic wr_tgt;
        logic rd_mode;

        assign ch_hit  = (reg_ch == CH_W'(i));
        assign wr_cnt  = reg_wr && ch_hit && (sel_e == SEL_COUNT);
        assign wr_mode = reg_wr && ch_hit && (sel_e == SEL_MODE);
        assign wr_tgt  = reg_wr && ch_hit && (sel_e == SEL_TARGET);
        assign rd_mode = reg_rd && ch_hit && (sel_e == SEL_MODE);

        if (i == 0) begin : g_dot
            assign tick[i] = view[i].mode[BIT_ALT_SRC] ? dot_tick : 1'b1;
        end else if (i == 1) begin : g_line
            assign tick[i] = view[i].mode[BIT_ALT_SRC] ? line_tick : 1'b1;
        end else if (i == DIV_CH) begin : g_div
            logic pre_tick;
            pit_prescaler #(.DIV(PRE_DIV)) u_pre (
                .clk     (clk),
                .rst     (rst),
                .restart (wr_mode),
                .tick_o  (pre_tick)
            );
            assign tick[i] = view[i].mode[BIT_STOP] ? 1'b0 :
                             view[i].mode[BIT_DIV]  ? pre_tick : 1'b1;
        end else begin : g_sys
            assign tick[i] = 1'b1;
        end

        pit_channel u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick[i]),
            .wr_cnt  (wr_cnt),
            .wr_mode (wr_mode),
            .wr_tgt  (wr_tgt),
            .rd_mode (rd_mode),
            .wdata   (reg_wdata[REG_W-1:0]),
            .view_o  (view[i]),
            .irq_q   (irq_q[i])
        );

        assign rep_vec[i] = view[i].mode[BIT_REPEAT];
        assign cnt_flat[i*REG_W +: REG_W] = view[i].cnt;
    end

    assign div_stop = view[DIV_CH].mode[BIT_STOP];

    pit_read_mux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rmux (
        .reg_ch (reg_ch),
        .sel    (sel_e),
        .view   (view),
        .rdata  (reg_rdata)
    );

    always_comb begin
        irq_set = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            irq_set[IRQ_BASE + i] = irq_q[i];
        end
    end

endmodule

// File: rtl/pit_timer_bank_chk.sv
module pit_timer_bank_chk
    import pit_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int CH_W     = 2,
    parameter int IRQ_W    = 16,
    parameter int IRQ_BASE = 4,
    parameter int DIV_CH   = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    reg_wr,
    input logic [CH_W-1:0]         reg_ch,
    input logic [1:0]              reg_sel,
    input logic [REG_W-1:0]        wdata_lo,
    input logic [IRQ_W-1:0]        irq_set,
    input logic [NUM_CH*REG_W-1:0] cnt_flat,
    input logic [NUM_CH-1:0]       rep_vec,
    input logic                    div_stop
);
    localparam logic [IRQ_W-1:0] IRQ_MASK = IRQ_W'(((1 << NUM_CH) - 1) << IRQ_BASE);

    // R7
    irq_outside_range_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_set & ~IRQ_MASK) == '0);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_p
        // R6
        mode_wr_clears_cnt_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_ch == CH_W'(i) && reg_sel == 2'd1)
            |=> cnt_flat[i*REG_W +: REG_W] == '0);

        // R2
        cnt_wr_low_half_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_ch == CH_W'(i) && reg_sel == 2'd0)
            |=> cnt_flat[i*REG_W +: REG_W] == $past(wdata_lo));

        // R11
        tgt_wr_holds_cnt_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_ch == CH_W'(i) && reg_sel == 2'd2)
            |=> $stable(cnt_flat[i*REG_W +: REG_W]));

        // R8
        one_shot_no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
            (irq_set[IRQ_BASE + i] && !rep_vec[i])
            |=> !irq_set[IRQ_BASE + i]);
    end

    // R10
    div_ch_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (div_stop && !(reg_wr && reg_ch == CH_W'(DIV_CH)))
        |=> $stable(cnt_flat[DIV_CH*REG_W +: REG_W]));

endmodule

bind pit_timer_bank pit_timer_bank_chk #(
    .NUM_CH   (NUM_CH),
    .CH_W     (CH_W),
    .IRQ_W    (IRQ_W),
    .IRQ_BASE (IRQ_BASE),
    .DIV_CH   (DIV_CH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_ch   (reg_ch),
    .reg_sel  (reg_sel),
    .wdata_lo (reg_wdata[15:0]),
    .irq_set  (irq_set),
    .cnt_flat (cnt_flat),
    .rep_vec  (rep_vec),
    .div_stop (div_stop)
);

// File: tb/pit_timer_bank_tb.sv
module pit_timer_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0, rd = 1'b0;
    logic [1:0]  ch = 2'd0, sel = 2'd0;
    logic [31:0] wd = '0;
    logic        dot = 1'b0, line = 1'b0;
    logic [15:0] rdata;
    logic [15:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    pit_timer_bank dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (wr),
        .reg_rd    (rd),
        .reg_ch    (ch),
        .reg_sel   (sel),
        .reg_wdata (wd),
        .reg_rdata (rdata),
        .dot_tick  (dot),
        .line_tick (line),
        .irq_set   (irq)
    );

    always #4 clk = ~clk;

    // Reference model built from the requirements
    logic [15:0] m_cnt [3];
    logic [15:0] m_tgt [3];
    logic [10:0] m_mode [3];
    logic        m_fh [3], m_fo [3], m_fired [3], m_irq [3];
    int          m_pre;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = 0; m_tgt[i] = 0; m_mode[i] = 0;
                m_fh[i] = 0; m_fo[i] = 0; m_fired[i] = 0; m_irq[i] = 0;
            end
            m_pre = 0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                logic wsel, tk, hit, ovf, pulse;
                logic [15:0] nxt;
                wsel = wr && (ch == 2'(i)) && (sel != 2'd3);
                case (i)
                    0: tk = m_mode[0][8] ? dot : 1'b1;
                    1: tk = m_mode[1][8] ? line : 1'b1;
                    default: tk = m_mode[2][0] ? 1'b0 : (m_mode[2][9] ? (m_pre == 7) : 1'b1);
                endcase
                if (i == 2) begin
                    if (wsel && sel == 2'd1) m_pre = 0;
                    else m_pre = (m_pre == 7) ? 0 : m_pre + 1;
                end
                hit = 0; ovf = 0;
                if (wsel) begin
                    case (sel)
                        2'd0: m_cnt[i] = wd[15:0];
                        2'd1: begin
                            m_mode[i] = wd[10:0]; m_cnt[i] = 0;
                            m_fh[i] = 0; m_fo[i] = 0; m_fired[i] = 0;
                        end
                        default: m_tgt[i] = wd[15:0];
                    endcase
                end else if (tk) begin
                    nxt = m_cnt[i] + 16'd1;
                    hit = (nxt == m_tgt[i]);
                    ovf = (m_cnt[i] == 16'hFFFF);
                    m_cnt[i] = (m_mode[i][3] && hit) ? 16'd0 : nxt;
                end
                if (!(wsel && sel == 2'd1)) begin
                    if (rd && ch == 2'(i) && sel == 2'd1) begin
                        m_fh[i] = 0; m_fo[i] = 0;
                    end
                    m_fh[i] = m_fh[i] | hit;
                    m_fo[i] = m_fo[i] | ovf;
                end
                pulse = ((m_mode[i][4] && hit) || (m_mode[i][5] && ovf)) &&
                        (m_mode[i][6] || !m_fired[i]);
                m_fired[i] = m_fired[i] | pulse;
                m_irq[i] = pulse;
            end
        end
    end

    function automatic logic [15:0] exp_read(input logic [1:0] c, input logic [1:0] s);
        if (c == 2'd3) return 16'd0;
        case (s)
            2'd0: return m_cnt[c];
            2'd1: return {3'b000, m_fo[c], m_fh[c], m_mode[c]};
            2'd2: return m_tgt[c];
            default: return 16'd0;
        endcase
    endfunction

    function automatic logic [15:0] exp_irq();
        logic [15:0] v;
        v = '0;
        for (int i = 0; i < 3; i++) v[4 + i] = m_irq[i];
        return v;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: check last edge's irq, drive new inputs, check the read
    task automatic cyc(input logic w, input logic r, input logic [1:0] c,
                       input logic [1:0] s, input logic [31:0] d,
                       input logic dt, input logic ln, input string req);
        @(negedge clk);
        check("R7 irq pulse", irq, exp_irq());
        wr = w; rd = r; ch = c; sel = s; wd = d; dot = dt; line = ln;
        #1;
        if (r) check(req, rdata, exp_read(c, s));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 2'd3, 2'd3, 0, 0, 0, "");
    endtask

    task automatic wreg(input logic [1:0] c, input logic [1:0] s, input logic [31:0] d);
        cyc(1, 0, c, s, d, 0, 0, "");
    endtask

    task automatic rreg(input logic [1:0] c, input logic [1:0] s, input string req);
        cyc(0, 1, c, s, 0, 0, 0, req);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int pulses;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rreg(2'd0, 2'd1, "R1 mode after reset");
        check("R1 mode literal", rdata, 16'h0000);
        rreg(2'd2, 2'd2, "R1 target after reset");
        check("R1 target literal", rdata, 16'h0000);
        check("R1 irq after reset", irq, 16'h0000);

        // R2 truncation, R11 write suppresses increment
        wreg(2'd1, 2'd2, 32'hDEAD_0005);
        rreg(2'd1, 2'd2, "R2 target truncated");
        check("R2 target literal", rdata, 16'h0005);
        wreg(2'd0, 2'd0, 32'hABCD_0064);
        wreg(2'd0, 2'd2, 32'h0000_0700);
        rreg(2'd0, 2'd0, "R11 count held by target write");
        check("R11 count literal", rdata, 16'd100);

        // R6 mode write zeroes count, high bits ignored
        wreg(2'd0, 2'd1, 32'h0000_F800);
        rreg(2'd0, 2'd0, "R6 count after mode write");
        check("R6 count literal", rdata, 16'd0);
        rreg(2'd0, 2'd1, "R6 mode high bits dropped");
        check("R6 mode literal", rdata, 16'h0000);

        // R4 target wrap with repeating irq
        wreg(2'd0, 2'd2, 32'd5);
        wreg(2'd0, 2'd1, 32'h0058);
        idle(20);
        rreg(2'd0, 2'd1, "R4 target flag set");
        check("R4 flag bit 11", {15'd0, rdata[11]}, 16'd1);
        rreg(2'd0, 2'd1, "R5 flags after read-clear");

        // R3 overflow with one-shot irq
        wreg(2'd1, 2'd1, 32'h0020);
        wreg(2'd1, 2'd0, 32'h0000_FFFC);
        idle(6);
        rreg(2'd1, 2'd1, "R3 overflow flag");
        check("R3 flag bit 12", {15'd0, rdata[12]}, 16'd1);
        rreg(2'd1, 2'd0, "R3 count wrapped");

        // R8 one-shot: only one pulse after mode write
        wreg(2'd0, 2'd2, 32'd3);
        wreg(2'd0, 2'd1, 32'h0018);
        pulses = 0;
        for (int k = 0; k < 20; k++) begin
            idle(1);
            if (irq[4]) pulses++;
        end
        check("R8 one-shot pulse count", 16'(pulses), 16'd1);

        // R9 external sources
        wreg(2'd1, 2'd1, 32'h0100);
        for (int k = 0; k < 5; k++) cyc(0, 0, 2'd3, 2'd3, 0, 1, 1, "");
        rreg(2'd1, 2'd0, "R9 line-driven count");
        check("R9 line literal", rdata, 16'd5);
        wreg(2'd0, 2'd1, 32'h0100);
        for (int k = 0; k < 6; k++) cyc(0, 0, 2'd3, 2'd3, 0, k[0], 0, "");
        rreg(2'd0, 2'd0, "R9 dot-driven count");
        check("R9 dot literal", rdata, 16'd3);

        // R10 divide by eight and stop
        wreg(2'd2, 2'd1, 32'h0200);
        idle(16);
        rreg(2'd2, 2'd0, "R10 divided count");
        check("R10 divide literal", rdata, 16'd2);
        wreg(2'd2, 2'd1, 32'h0201);
        idle(12);
        rreg(2'd2, 2'd0, "R10 stopped count");
        check("R10 stop literal", rdata, 16'd0);

        // Random phase
        for (int k = 0; k < 4000; k++) begin
            logic        w, r;
            logic [1:0]  c, s;
            logic [31:0] d;
            w = ($urandom % 6) == 0;
            r = ($urandom % 3) == 0;
            c = 2'($urandom % 4);
            s = 2'($urandom % 4);
            d = $urandom;
            if (w && s == 2'd2) d = $urandom % 12;
            if (w && s == 2'd0 && ($urandom % 2)) d = 32'hFFF0 | ($urandom % 16);
            cyc(w, r, c, s, d, 1'($urandom), 1'($urandom), "R5 random readback");
        end
        idle(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule